// File: doc/BRIEF.md
# Data Register File with Guarded Accumulators

This block is the operand store of a 20-bit fixed-point signal-processing datapath. It keeps eight registers. Indices 0 to 5 are plain 20-bit registers. Indices 6 and 7 are 48-bit accumulators. Each accumulator is laid out as an 8-bit guard field over a 40-bit double-precision product field. In every cycle, four independent read ports each deliver a 20-bit operand, and two write ports each take a 20-bit result.

When a 20-bit read port addresses an accumulator, a per-port slice code picks which part of it is returned. The choices are the upper product half, the lower product half, the guard byte, or a saturated upper half. When a 20-bit write targets an accumulator, the value lands in the upper product half, is sign-extended into the guard byte, and the lower half is cleared.

A separate pair of 48-bit ports lets the arithmetic unit load and observe each accumulator at full width. A full-width load takes precedence over any 20-bit write to the same accumulator in that cycle. Reads always see the contents from before the current clock edge.

Top module: `dsp_regfile`

## Requirements
- R1: While reset is asserted (rstN low) and after its release, every register holds zero: all read ports return 0 and both full-width accumulator outputs are 0.
- R2: A 20-bit write to register index 0 to 5 is returned unchanged by any read port addressing that index from the next cycle on. All four read ports work independently in the same cycle.
- R3: The two write ports targeting different registers in the same cycle both take effect.
- R4: When both write ports are enabled for the same register in one cycle, the value of port 0 is stored.
- R5: A read in the same cycle as a write to the same register returns the value from before that write; there is no bypass.
- R6: A 20-bit write of value v to accumulator index 6 or 7 stores {eight copies of v[19], v, twenty zero bits}.
- R7: For an accumulator read, slice code 0 returns bits 39:20, code 1 returns bits 19:0, and code 2 returns bits 47:40 sign-extended to 20 bits.
- R8: Slice code 3 returns bits 39:20 when bits 47:39 are all equal. Otherwise it returns 0x7FFFF if bit 47 is 0, or 0x80000 if bit 47 is 1.
- R9: The slice code has no effect when the read address is 0 to 5.
- R10: Full-width port k (k = 0, 1) loads accumulator index 6+k with all 48 bits when its enable is high. In that cycle it overrides any 20-bit write to the same accumulator.
- R11: Full-width output k always shows the complete 48-bit contents of accumulator 6+k.
- R12: A register targeted by no enabled write holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rdAddr | input | 4x3 | Register index per read port |
| rdSlice | input | 4x2 | Accumulator slice code per read port |
| rdData | output | 4x20 | Read operand per port |
| wrEn | input | 2 | Write enable per 20-bit write port |
| wrAddr | input | 2x3 | Target index per write port |
| wrData | input | 2x20 | Write value per port |
| accWrEn | input | 2 | Full-width load enable per accumulator |
| accWrData | input | 2x48 | Full-width load value per accumulator |
| accRdData | output | 2x48 | Full contents of each accumulator |

## Verification
Storage is observed only through the read ports and the full-width outputs. A corrupted register or a wrongly decoded write therefore appears on the first read of that index after the offending clock edge. For the accumulators it also appears on the full-width output in the very next cycle. A priority or extension fault shows up as a wrong guard byte or a wrong upper half one cycle after the write. A fault in the slice multiplexer appears combinationally, in the same cycle, on whichever port carries the affected slice code. The sweep crosses every pair of write targets with every full-width enable pattern, and rotates read addresses and slice codes so that all of these paths are compared against an arithmetic model.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  parameter int RF_DATA_W   = 20;
  parameter int RF_GUARD_W  = 8;
  parameter int RF_REGS     = 8;
  parameter int RF_ACCS     = 2;
  parameter int RF_RD_PORTS = 4;
  parameter int RF_WR_PORTS = 2;

  localparam int RF_ACC_W     = RF_GUARD_W + 2 * RF_DATA_W;
  localparam int RF_ADDR_W    = $clog2(RF_REGS);
  localparam int RF_ACC_BASE  = RF_REGS - RF_ACCS;
  localparam int RF_NARROW    = RF_ACC_BASE;
  localparam int RF_ACC_IDX_W = (RF_ACCS > 1) ? $clog2(RF_ACCS) : 1;
  localparam int RF_WSEL_W    = (RF_WR_PORTS > 1) ? $clog2(RF_WR_PORTS) : 1;

  typedef enum logic [1:0] {
    SLICE_HIGH  = 2'd0,
    SLICE_LOW   = 2'd1,
    SLICE_GUARD = 2'd2,
    SLICE_SAT   = 2'd3
  } slice_e;

  // strobes from write decode to storage
  typedef struct packed {
    logic [RF_REGS-1:0]                 narrowWe;
    logic [RF_REGS-1:0][RF_WSEL_W-1:0]  narrowSel;
    logic [RF_ACCS-1:0]                 wideWe;
  } wr_strobe_t;
endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [RF_WR_PORTS-1:0]                wrEn,
  input  logic [RF_WR_PORTS-1:0][RF_ADDR_W-1:0] wrAddr,
  input  logic [RF_ACCS-1:0]                    accWrEn,
  output wr_strobe_t                            strobe
);
  // Scan ports from the highest index down so the lowest port is applied last and wins.
  always_comb begin
    strobe = '0;
    for (int r = 0; r < RF_REGS; r++) begin
      for (int p = RF_WR_PORTS - 1; p >= 0; p--) begin
        if (wrEn[p] && (wrAddr[p] == RF_ADDR_W'(r))) begin
          strobe.narrowWe[r]  = 1'b1;
          strobe.narrowSel[r] = RF_WSEL_W'(p);
        end
      end
    end
    strobe.wideWe = accWrEn;
  end

  // R4: a register hit by port 0 must be sourced from port 0
  p_port0_selected_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn[0] |-> (strobe.narrowWe[wrAddr[0]] && strobe.narrowSel[wrAddr[0]] == '0));

  // R12: no enable means no strobe
  p_idle_no_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn == '0) |-> (strobe.narrowWe == '0));
endmodule

// File: rtl/regfile_rd_port.sv
module regfile_rd_port
  import regfile_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [RF_ADDR_W-1:0]                  addr,
  input  logic [1:0]                            slice,
  input  logic [RF_NARROW-1:0][RF_DATA_W-1:0]   narrowQ,
  input  logic [RF_ACCS-1:0][RF_ACC_W-1:0]      accQ,
  output logic [RF_DATA_W-1:0]                  data
);
  localparam int TOP_W = RF_GUARD_W + 1;
  localparam logic [RF_DATA_W-1:0] POS_MAX = {1'b0, {(RF_DATA_W-1){1'b1}}};
  localparam logic [RF_DATA_W-1:0] NEG_MIN = {1'b1, {(RF_DATA_W-1){1'b0}}};

  logic [RF_ACC_IDX_W-1:0] accIdx;
  logic [RF_ACC_W-1:0]     accWord;
  logic [TOP_W-1:0]        topBits;
  logic                    topUniform;
  logic [RF_DATA_W-1:0]    hiPart, loPart, guardExt, satPart;
  logic                    isAcc;
  slice_e                  sliceCode;

  assign isAcc      = (addr >= RF_ADDR_W'(RF_ACC_BASE));
  assign accIdx     = RF_ACC_IDX_W'(addr - RF_ADDR_W'(RF_ACC_BASE));
  assign accWord    = accQ[accIdx];
  assign topBits    = accWord[RF_ACC_W-1 -: TOP_W];
  assign topUniform = (&topBits) || (~|topBits);
  assign hiPart     = accWord[2*RF_DATA_W-1 -: RF_DATA_W];
  assign loPart     = accWord[RF_DATA_W-1:0];
  assign guardExt   = {{(RF_DATA_W-RF_GUARD_W){accWord[RF_ACC_W-1]}},
                       accWord[RF_ACC_W-1 -: RF_GUARD_W]};
  assign satPart    = topUniform ? hiPart
                    : (accWord[RF_ACC_W-1] ? NEG_MIN : POS_MAX);
  assign sliceCode  = slice_e'(slice);

  always_comb begin
    if (!isAcc) begin
      data = narrowQ[addr];
    end else begin
      unique case (sliceCode)
        SLICE_HIGH:  data = hiPart;
        SLICE_LOW:   data = loPart;
        SLICE_GUARD: data = guardExt;
        default:     data = satPart;
      endcase
    end
  end

  // R8: a clipped read is one of the two limits
  p_sat_limits_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isAcc && sliceCode == SLICE_SAT && !topUniform) |-> (data == POS_MAX || data == NEG_MIN));

  // R7: guard slice upper bits all copy the accumulator sign
  p_guard_sext_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isAcc && sliceCode == SLICE_GUARD) |->
      ((&data[RF_DATA_W-1:RF_GUARD_W-1]) || (~|data[RF_DATA_W-1:RF_GUARD_W-1])));
endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import regfile_pkg::*;
(
  input  logic                                    clk,
  input  logic                                    rstN,
  input  wr_strobe_t                              strobe,
  input  logic [RF_WR_PORTS-1:0][RF_DATA_W-1:0]   wrData,
  input  logic [RF_ACCS-1:0][RF_ACC_W-1:0]        accWrData,
  input  logic [RF_RD_PORTS-1:0][RF_ADDR_W-1:0]   rdAddr,
  input  logic [RF_RD_PORTS-1:0][1:0]             rdSlice,
  output logic [RF_RD_PORTS-1:0][RF_DATA_W-1:0]   rdData,
  output logic [RF_ACCS-1:0][RF_ACC_W-1:0]        accQ
);
  logic [RF_NARROW-1:0][RF_DATA_W-1:0] narrowQ;

  for (genvar r = 0; r < RF_NARROW; r++) begin : g_narrow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   narrowQ[r] <= '0;
      else if (strobe.narrowWe[r]) narrowQ[r] <= wrData[strobe.narrowSel[r]];
    end

    // R12: untargeted plain register holds
    p_narrow_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.narrowWe[r] |=> $stable(narrowQ[r]));
  end

  for (genvar k = 0; k < RF_ACCS; k++) begin : g_acc
    localparam int REG_IDX = RF_ACC_BASE + k;
    logic [RF_DATA_W-1:0] narrowVal;
    logic [RF_ACC_W-1:0]  extended;

    assign narrowVal = wrData[strobe.narrowSel[REG_IDX]];
    assign extended  = {{RF_GUARD_W{narrowVal[RF_DATA_W-1]}}, narrowVal, {RF_DATA_W{1'b0}}};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         accQ[k] <= '0;
      else if (strobe.wideWe[k])         accQ[k] <= accWrData[k];
      else if (strobe.narrowWe[REG_IDX]) accQ[k] <= extended;
    end

    // R12: untargeted accumulator holds
    p_acc_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.wideWe[k] && !strobe.narrowWe[REG_IDX]) |=> $stable(accQ[k]));
  end

  for (genvar p = 0; p < RF_RD_PORTS; p++) begin : g_rd
    regfile_rd_port u_rd (
      .clk     (clk),
      .rstN    (rstN),
      .addr    (rdAddr[p]),
      .slice   (rdSlice[p]),
      .narrowQ (narrowQ),
      .accQ    (accQ),
      .data    (rdData[p])
    );
  end
endmodule

// File: rtl/dsp_regfile.sv
module dsp_regfile
  import regfile_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [RF_RD_PORTS-1:0][RF_ADDR_W-1:0] rdAddr,
  input  logic [RF_RD_PORTS-1:0][1:0]           rdSlice,
  output logic [RF_RD_PORTS-1:0][RF_DATA_W-1:0] rdData,
  input  logic [RF_WR_PORTS-1:0]                wrEn,
  input  logic [RF_WR_PORTS-1:0][RF_ADDR_W-1:0] wrAddr,
  input  logic [RF_WR_PORTS-1:0][RF_DATA_W-1:0] wrData,
  input  logic [RF_ACCS-1:0]                    accWrEn,
  input  logic [RF_ACCS-1:0][RF_ACC_W-1:0]      accWrData,
  output logic [RF_ACCS-1:0][RF_ACC_W-1:0]      accRdData
);
  wr_strobe_t strobe;

  regfile_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .accWrEn (accWrEn),
    .strobe  (strobe)
  );

  regfile_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .accWrData (accWrData),
    .rdAddr    (rdAddr),
    .rdSlice   (rdSlice),
    .rdData    (rdData),
    .accQ      (accRdData)
  );

  for (genvar k = 0; k < RF_ACCS; k++) begin : g_chk
    localparam logic [RF_ADDR_W-1:0] IDX = RF_ADDR_W'(RF_ACC_BASE + k);

    // R10: full-width load appears whole on the next cycle
    p_wide_load_r10: assert property (@(posedge clk) disable iff (!rstN)
      accWrEn[k] |=> (accRdData[k] == $past(accWrData[k])));

    // R6: 20-bit write from port 0 is sign-extended with cleared low half
    p_narrow_ext_r6: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn[0] && wrAddr[0] == IDX && !accWrEn[k]) |=>
        (accRdData[k] == {{RF_GUARD_W{$past(wrData[0][RF_DATA_W-1])}},
                          $past(wrData[0]), {RF_DATA_W{1'b0}}}));

    // R4: port 0 wins on a shared accumulator target
    p_port0_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn[0] && wrEn[1] && wrAddr[0] == IDX && wrAddr[1] == IDX && !accWrEn[k]) |=>
        (accRdData[k][2*RF_DATA_W-1 -: RF_DATA_W] == $past(wrData[0])));
  end
endmodule

// File: tb/test_dsp_regfile.sv
module test_dsp_regfile;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rstN;
  logic [3:0][2:0]  rdAddr;
  logic [3:0][1:0]  rdSlice;
  logic [3:0][19:0] rdData;
  logic [1:0]       wrEn;
  logic [1:0][2:0]  wrAddr;
  logic [1:0][19:0] wrData;
  logic [1:0]       accWrEn;
  logic [1:0][47:0] accWrData;
  logic [1:0][47:0] accRdData;

  logic [47:0] model [8];
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;
  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_regfile i_dsp_regfile (
    .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .rdSlice(rdSlice), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .accWrEn(accWrEn), .accWrData(accWrData), .accRdData(accRdData)
  );

  function automatic logic [63:0] nextRand(logic [63:0] s);
    logic [63:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  // expected 20-bit read per R2, R7, R8, R9
  function automatic logic [19:0] expRead(int r, int s);
    logic [47:0] a = model[r];
    if (r < 6) return a[19:0];
    case (s)
      0: return a[39:20];
      1: return a[19:0];
      2: return {{12{a[47]}}, a[47:40]};
      default: begin
        if (a[47:39] == 9'h000 || a[47:39] == 9'h1FF) return a[39:20];
        return a[47] ? 20'h80000 : 20'h7FFFF;
      end
    endcase
  endfunction

  function automatic string readTag(int r, int s);
    if (r < 6) return (s == 0) ? "R2" : "R9";
    return (s == 3) ? "R8" : "R7";
  endfunction

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string extra);
    for (int p = 0; p < 4; p++)
      check($sformatf("%s %s port%0d", readTag(int'(rdAddr[p]), int'(rdSlice[p])), extra, p),
            48'(rdData[p]), 48'(expRead(int'(rdAddr[p]), int'(rdSlice[p]))));
    for (int k = 0; k < 2; k++)
      check($sformatf("R11 %s acc%0d", extra, k), accRdData[k], model[6+k]);
  endtask

  // one clock edge with model update per R3, R4, R6, R10, R12
  task automatic edgeStep();
    logic [47:0] nm [8];
    for (int r = 0; r < 8; r++) begin
      logic hit = 1'b0;
      logic [19:0] v = '0;
      nm[r] = model[r];
      if (wrEn[1] && wrAddr[1] == 3'(r)) begin hit = 1'b1; v = wrData[1]; end
      if (wrEn[0] && wrAddr[0] == 3'(r)) begin hit = 1'b1; v = wrData[0]; end
      if (hit) nm[r] = (r >= 6) ? {{8{v[19]}}, v, 20'h0} : {28'h0, v};
    end
    for (int k = 0; k < 2; k++) if (accWrEn[k]) nm[6+k] = accWrData[k];
    @(posedge clk);
    for (int r = 0; r < 8; r++) model[r] = nm[r];
    @(negedge clk);
  endtask

  task automatic idleInputs();
    wrEn = '0; accWrEn = '0; wrAddr = '0; wrData = '0; accWrData = '0;
  endtask

  task automatic sweepReads(string extra);
    for (int base = 0; base < 8; base += 4)
      for (int s = 0; s < 4; s++) begin
        for (int p = 0; p < 4; p++) begin
          rdAddr[p]  = 3'(base + p);
          rdSlice[p] = 2'(s + p);
        end
        #1 checkAll(extra);
      end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) model[r] = '0;
    rstN = 1'b0; idleInputs(); rdAddr = '0; rdSlice = '0;
    repeat (3) @(negedge clk);
    sweepReads("R1 in-reset");
    rstN = 1'b1;
    @(negedge clk);
    sweepReads("R1 after-release");

    // write-pair sweep with full-width enable patterns
    for (int a0 = 0; a0 < 8; a0++)
      for (int a1 = 0; a1 < 8; a1++)
        for (int m = 0; m < 4; m++) begin
          string tag;
          lfsr = nextRand(lfsr);
          wrEn = 2'b11;
          wrAddr[0] = 3'(a0); wrAddr[1] = 3'(a1);
          wrData[0] = lfsr[19:0]; wrData[1] = lfsr[43:24];
          if (m == 1) wrData[0] = 20'h80000;
          accWrEn = 2'(m);
          accWrData[0] = lfsr[47:0];
          lfsr = nextRand(lfsr);
          accWrData[1] = lfsr[63:16];
          if (m == 3) accWrData[1] = 48'h00_80000_00001;
          for (int p = 0; p < 4; p++) begin
            rdAddr[p]  = (p < 2) ? 3'(p == 0 ? a0 : a1) : 3'(a0 + p);
            rdSlice[p] = 2'(a1 + p + m);
          end
          #1 checkAll("R5 R12");
          edgeStep();
          if (a0 >= 6 && accWrEn[a0-6]) tag = "R10";
          else if (a0 >= 6) tag = "R6";
          else if (a0 == a1) tag = "R4";
          else tag = "R3";
          idleInputs();
          rdAddr[0] = 3'(a0); rdAddr[1] = 3'(a1); rdAddr[2] = 3'(a0); rdAddr[3] = 3'(a1);
          rdSlice[0] = 2'd0; rdSlice[1] = 2'd0; rdSlice[2] = 2'd1; rdSlice[3] = 2'd3;
          #1 checkAll(tag);
          edgeStep();
        end

    // directed saturation and guard cases
    begin
      logic [47:0] pats [4];
      pats[0] = 48'h00_80000_00000;
      pats[1] = 48'hFF_7FFFF_00000;
      pats[2] = 48'hFF_80000_12345;
      pats[3] = 48'h7F_00000_FFFFF;
      for (int i = 0; i < 4; i++) begin
        accWrEn = 2'b11;
        accWrData[0] = pats[i];
        accWrData[1] = pats[3-i];
        wrEn = 2'b11; wrAddr[0] = 3'd6; wrAddr[1] = 3'd7; wrData = '0;
        edgeStep();
        idleInputs();
        sweepReads("R10 R8");
      end
    end

    // same-cycle read of a register being rewritten
    wrEn = 2'b01; wrAddr[0] = 3'd3; wrData[0] = ~model[3][19:0];
    rdAddr = '{3'd3, 3'd3, 3'd3, 3'd3}; rdSlice = '{2'd0, 2'd1, 2'd2, 2'd3};
    #1 check("R5 direct", 48'(rdData[0]), model[3]);
    edgeStep();
    idleInputs();
    #1 check("R2 direct", 48'(rdData[0]), model[3]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule